// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller that serves several banks of pins, 32 pins per bank, three banks by default. A plain 32-bit read/write register bus gives software control over each pin. Per bank it can set the pin direction, invert the input, and drive the output value. The output value can be loaded as a whole word, or changed one bit at a time through separate set and clear ports.

Every input pin goes through a synchronizer chain and then an optional inversion. The corrected value is used for data readback and for event detection. Each pin has four separate event enables: rising edge, falling edge, high level and low level. Any mix of them can be active at once. A detected event latches into a per-bank status register, and software clears a bit by writing 1 to it. A single interrupt line is high while any status bit in any bank is set. A read-only per-bank word records whether the latest event on each pin came from an edge detector or from a level detector.

The bus has no handshake. A write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the address while `bus_en` is high and `bus_we` is low. There is no stream traffic, so no back-pressure applies.

Top module: `tribank_gpio`

## Requirements
- R1: Register address = {group[3:0], bank[1:0], 2'b00}. Group codes: 0 direction, 1 inversion, 2 data, 3 set port, 4 clear port, 5 rise enable, 6 fall enable, 7 high enable, 8 low enable, 9 status, 10 event source. Any of the following reads 0 and ignores writes: a group above 10, a bank at or above the bank count, or nonzero address bits [1:0].
- R2: A 1 in a direction bit makes that pin an output, so `pin_oe` for the pin is 1. A data-register read returns the driven value for output pins.
- R3: A write to the data group loads the output word. A 1 in a set-port write drives that bit high, and a 1 in a clear-port write drives it low. Zero bits leave the output as it was. The set and clear ports read as 0.
- R4: An input change appears in the data readback of an input pin after the second rising clock edge, and not after the first.
- R5: An inversion bit of 1 inverts that pin's input before readback and before event detection. Changing the bit is seen by the detectors as an input change.
- R6: The rise and fall enables latch status when the corrected input changes between two consecutive synchronized samples. With both enables set, both directions are detected.
- R7: The high and low enables set status on every clock while the corrected input holds the enabled level. This includes the cycle in which software clears the bit.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is 1 exactly while at least one status bit in any bank is 1.
- R10: Event-source bit = 1 when the latest event latched for that pin came from an edge enable. It is 0 when that event came only from a level enable. If both fire in one cycle, the edge wins. Writes to this group have no effect.
- R11: After reset every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: group, bank, 2'b00 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 96 | Raw pad inputs, bank b at bits [32b+31:32b] |
| pin_out | output | 96 | Driven output values |
| pin_oe | output | 96 | Output enables, taken from the direction bits |
| irq | output | 1 | Shared interrupt |

## Verification
The functions that can land in the same cycle are a software clear of a status bit and a fresh hardware event on that same bit. The directed part provokes this in two ways. First, a rising edge is timed so that its detection cycle matches the clear-port write exactly. Second, a clear is written while a level enable keeps firing. Both cases are judged by reading the status word afterwards and expecting the bit to still be 1. Random traffic mixes status clears with pin toggles and inversion flips, and a bench reference model tracks every such coincidence.

// File: rtl/tribank_gpio_pkg.sv
package tribank_gpio_pkg;
  localparam int GRP_W     = 4;
  localparam int BSEL_W    = 2;
  localparam int ADDR_W    = GRP_W + BSEL_W + 2;
  localparam int MAX_BANKS = 1 << BSEL_W;

  localparam logic [GRP_W-1:0] G_DIR  = 4'd0;
  localparam logic [GRP_W-1:0] G_INV  = 4'd1;
  localparam logic [GRP_W-1:0] G_DATA = 4'd2;
  localparam logic [GRP_W-1:0] G_SET  = 4'd3;
  localparam logic [GRP_W-1:0] G_CLR  = 4'd4;
  localparam logic [GRP_W-1:0] G_RISE = 4'd5;
  localparam logic [GRP_W-1:0] G_FALL = 4'd6;
  localparam logic [GRP_W-1:0] G_HIGH = 4'd7;
  localparam logic [GRP_W-1:0] G_LOW  = 4'd8;
  localparam logic [GRP_W-1:0] G_STAT = 4'd9;
  localparam logic [GRP_W-1:0] G_SRC  = 4'd10;
  localparam logic [GRP_W-1:0] G_LAST = G_SRC;

  function automatic logic [ADDR_W-1:0] reg_addr(input logic [GRP_W-1:0] grp,
                                                 input int unsigned bank);
    return {grp, BSEL_W'(bank), 2'b00};
  endfunction
endpackage

// File: rtl/tribank_sync.sv
module tribank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tribank_detect.sv
module tribank_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_now,
  input  logic [WIDTH-1:0] en_rise,
  input  logic [WIDTH-1:0] en_fall,
  input  logic [WIDTH-1:0] en_high,
  input  logic [WIDTH-1:0] en_low,
  output logic [WIDTH-1:0] hit_any,
  output logic [WIDTH-1:0] hit_edge
);
  logic [WIDTH-1:0] level_prev_q;
  logic [WIDTH-1:0] rise_hit, fall_hit, high_hit, low_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev_q <= '0;
    else        level_prev_q <= level_now;
  end

  always_comb begin
    rise_hit = level_now & ~level_prev_q & en_rise;
    fall_hit = ~level_now & level_prev_q & en_fall;
    high_hit = level_now & en_high;
    low_hit  = ~level_now & en_low;
    hit_edge = rise_hit | fall_hit;
    hit_any  = hit_edge | high_hit | low_hit;
  end
endmodule

// File: rtl/tribank_bank.sv
module tribank_bank
  import tribank_gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_grp,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [GRP_W-1:0] rd_grp,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             pending
);
  logic [WIDTH-1:0] dir_q, inv_q, dout_q;
  logic [WIDTH-1:0] en_rise_q, en_fall_q, en_high_q, en_low_q;
  logic [WIDTH-1:0] stat_q, src_q;
  logic [WIDTH-1:0] level_now, hit_any, hit_edge, clr_mask;

  assign level_now = pin_sync ^ inv_q;

  tribank_detect #(.WIDTH(WIDTH)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_now(level_now),
    .en_rise  (en_rise_q),
    .en_fall  (en_fall_q),
    .en_high  (en_high_q),
    .en_low   (en_low_q),
    .hit_any  (hit_any),
    .hit_edge (hit_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      inv_q     <= '0;
      dout_q    <= '0;
      en_rise_q <= '0;
      en_fall_q <= '0;
      en_high_q <= '0;
      en_low_q  <= '0;
    end else if (wr_en) begin
      case (wr_grp)
        G_DIR:   dir_q     <= wr_data;
        G_INV:   inv_q     <= wr_data;
        G_DATA:  dout_q    <= wr_data;
        G_SET:   dout_q    <= dout_q | wr_data;
        G_CLR:   dout_q    <= dout_q & ~wr_data;
        G_RISE:  en_rise_q <= wr_data;
        G_FALL:  en_fall_q <= wr_data;
        G_HIGH:  en_high_q <= wr_data;
        G_LOW:   en_low_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign clr_mask = (wr_en && wr_grp == G_STAT) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      src_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | hit_any;
      src_q  <= (src_q & ~hit_any) | hit_edge;
    end
  end

  always_comb begin
    case (rd_grp)
      G_DIR:   rd_data = dir_q;
      G_INV:   rd_data = inv_q;
      G_DATA:  rd_data = (dir_q & dout_q) | (~dir_q & level_now);
      G_RISE:  rd_data = en_rise_q;
      G_FALL:  rd_data = en_fall_q;
      G_HIGH:  rd_data = en_high_q;
      G_LOW:   rd_data = en_low_q;
      G_STAT:  rd_data = stat_q;
      G_SRC:   rd_data = src_q;
      default: rd_data = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
  assign pending = |stat_q;
endmodule

// File: rtl/tribank_gpio.sv
module tribank_gpio
  import tribank_gpio_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NPINS      = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [GRP_W-1:0]  a_grp;
  logic [BSEL_W-1:0] a_bank;
  logic              a_hit;
  logic [NPINS-1:0]  pin_sync;
  logic [NUM_BANKS-1:0] bank_wr, bank_pend;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rd;

  assign a_grp  = bus_addr[ADDR_W-1 -: GRP_W];
  assign a_bank = bus_addr[2 +: BSEL_W];
  assign a_hit  = (a_grp <= G_LAST) && (int'(a_bank) < NUM_BANKS) && (bus_addr[1:0] == 2'b00);

  tribank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pin_in),
    .q_sync (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_wr[b] = bus_en && bus_we && a_hit && (a_bank == BSEL_W'(b));

    tribank_bank #(.WIDTH(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr[b]),
      .wr_grp  (a_grp),
      .wr_data (bus_wdata),
      .rd_grp  (a_grp),
      .rd_data (bank_rd[b]),
      .pin_sync(pin_sync[b*BANK_W +: BANK_W]),
      .pad_out (pin_out[b*BANK_W +: BANK_W]),
      .pad_oe  (pin_oe[b*BANK_W +: BANK_W]),
      .pending (bank_pend[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bus_en && !bus_we && a_hit && a_bank == BSEL_W'(b)) bus_rdata = bank_rd[b];
  end

  assign irq = |bank_pend;
endmodule

// File: rtl/tribank_gpio_chk.sv
module tribank_gpio_chk
  import tribank_gpio_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  localparam int NPINS    = NUM_BANKS * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] bus_wdata,
  input logic [BANK_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  AST_UNMAPPED_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1 -: GRP_W] > G_LAST) |-> (bus_rdata == '0)); // R1

  AST_IRQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_en && bus_we)); // R8

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_DIR = reg_addr(G_DIR, b);
    localparam logic [ADDR_W-1:0] A_SET = reg_addr(G_SET, b);
    localparam logic [ADDR_W-1:0] A_CLR = reg_addr(G_CLR, b);

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == A_DIR) |=>
        (pin_oe[b*BANK_W +: BANK_W] == $past(bus_wdata))); // R2

    AST_SET_PORT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == A_SET) |=>
        ((pin_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_CLR_PORT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == A_CLR) |=>
        ((pin_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == '0)); // R3

    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == A_SET) |=>
        ((pin_out[b*BANK_W +: BANK_W] & ~$past(bus_wdata)) ==
         ($past(pin_out[b*BANK_W +: BANK_W]) & ~$past(bus_wdata)))); // R3
  end
endmodule

bind tribank_gpio tribank_gpio_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq      (irq)
);

// File: tb/tribank_gpio_bench.sv
`timescale 1ns/1ps
module tribank_gpio_bench;
  localparam int NB = 3;
  localparam int W  = 32;
  localparam int NP = NB * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          b_en = 1'b0, b_we = 1'b0;
  logic [7:0]    b_addr = '0;
  logic [W-1:0]  b_wdata = '0;
  logic [W-1:0]  rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tribank_gpio u_tribank_gpio (
    .clk(clk), .rst_n(rst_n), .bus_en(b_en), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // Reference model built from the requirements
  logic [NP-1:0] m_dir, m_inv, m_dout, m_ren, m_fen, m_hen, m_len, m_stat, m_src, m_s1, m_s2, m_prev;

  always @(posedge clk or negedge rst_n) begin
    logic [NP-1:0] cur, eg, ev, w1c;
    int k;
    if (!rst_n) begin
      m_dir <= '0; m_inv <= '0; m_dout <= '0; m_ren <= '0; m_fen <= '0; m_hen <= '0;
      m_len <= '0; m_stat <= '0; m_src <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
    end else begin
      cur = m_s2 ^ m_inv;
      eg  = (cur & ~m_prev & m_ren) | (~cur & m_prev & m_fen);
      ev  = eg | (cur & m_hen) | (~cur & m_len);
      w1c = '0;
      k   = int'(b_addr[3:2]) * W;
      if (b_en && b_we && b_addr[3:2] < 2'd3 && b_addr[1:0] == 2'b00) begin
        case (b_addr[7:4])
          4'd0: m_dir[k +: W]  <= b_wdata;
          4'd1: m_inv[k +: W]  <= b_wdata;
          4'd2: m_dout[k +: W] <= b_wdata;
          4'd3: m_dout[k +: W] <= m_dout[k +: W] | b_wdata;
          4'd4: m_dout[k +: W] <= m_dout[k +: W] & ~b_wdata;
          4'd5: m_ren[k +: W]  <= b_wdata;
          4'd6: m_fen[k +: W]  <= b_wdata;
          4'd7: m_hen[k +: W]  <= b_wdata;
          4'd8: m_len[k +: W]  <= b_wdata;
          4'd9: w1c[k +: W]     = b_wdata;
          default: ;
        endcase
      end
      m_stat <= (m_stat & ~w1c) | ev;
      m_src  <= (m_src & ~ev) | eg;
      m_s1   <= pins;
      m_s2   <= m_s1;
      m_prev <= cur;
    end
  end

  function automatic logic [W-1:0] exp_read(input logic [7:0] a);
    logic [NP-1:0] d;
    int k;
    if (a[3:2] > 2'd2 || a[7:4] > 4'd10 || a[1:0] != 2'b00) return '0;
    k = int'(a[3:2]) * W;
    d = (m_dir & m_dout) | (~m_dir & (m_s2 ^ m_inv));
    case (a[7:4])
      4'd0: return m_dir[k +: W];
      4'd1: return m_inv[k +: W];
      4'd2: return d[k +: W];
      4'd5: return m_ren[k +: W];
      4'd6: return m_fen[k +: W];
      4'd7: return m_hen[k +: W];
      4'd8: return m_len[k +: W];
      4'd9: return m_stat[k +: W];
      4'd10: return m_src[k +: W];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    b_en = 1'b1; b_we = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_en = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [W-1:0] mask, input logic [W-1:0] exp);
    b_en = 1'b1; b_we = 1'b0; b_addr = a;
    #1;
    chk(req, rdata & mask, exp);
    b_en = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);

    // R11: reset state
    for (int g = 0; g <= 10; g++)
      for (int b = 0; b < NB; b++) rd("R11 reset read", {4'(g), 2'(b), 2'b00}, '1, '0);
    chk("R11 oe after reset", pin_oe[W-1:0], '0);
    chk("R11 irq after reset", {31'd0, irq}, '0);

    // R1 and R2: addressing and direction
    wr(8'h04, 32'h0000A5A5);
    rd("R1 bank1 dir", 8'h04, '1, 32'h0000A5A5);
    rd("R1 bank0 untouched", 8'h00, '1, '0);
    chk("R2 oe bank1", pin_oe[2*W-1:W], 32'h0000A5A5);
    wr(8'h0C, 32'hFFFFFFFF);
    rd("R1 bank3 unmapped", 8'h0C, '1, '0);
    rd("R1 group 11 unmapped", 8'hB0, '1, '0);
    wr(8'h01, 32'hFFFFFFFF);
    rd("R1 misaligned write ignored", 8'h00, '1, '0);

    // R3: data, set and clear ports
    wr(8'h24, 32'h0);
    wr(8'h34, 32'h0000000F);
    chk("R3 set port drives high", {28'd0, pin_out[35:32]}, 32'hF);
    rd("R2 readback of outputs", 8'h24, 32'hF, 32'h5);
    wr(8'h44, 32'h00000003);
    chk("R3 clear port drives low", {28'd0, pin_out[35:32]}, 32'hC);
    wr(8'h34, 32'h0);
    chk("R3 zero bits in set unchanged", {28'd0, pin_out[35:32]}, 32'hC);
    rd("R3 set port reads zero", 8'h34, '1, '0);

    // R4: two-stage synchronizer
    pins[5] = 1'b1;
    wait_neg(1);
    rd("R4 not after one edge", 8'h20, 32'h20, 32'h0);
    wait_neg(1);
    rd("R4 visible after two edges", 8'h20, 32'h20, 32'h20);

    // R5: inversion in readback and detection
    wr(8'h50, 32'h40);
    wr(8'h10, 32'h60);
    wait_neg(1);
    rd("R5 inverted readback", 8'h20, 32'h60, 32'h40);
    rd("R5 inversion seen as edge", 8'h90, 32'h40, 32'h40);
    wr(8'h50, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h90, 32'hFFFFFFFF);
    chk("R9 irq low after clear", {31'd0, irq}, '0);

    // R6 rising, R8 zero write and collision, R10
    wr(8'h58, 32'h1);
    pins[64] = 1'b1;
    wait_neg(3);
    rd("R6 rising sets status", 8'h98, 32'h1, 32'h1);
    chk("R9 irq high", {31'd0, irq}, 32'h1);
    rd("R10 edge source", 8'hA8, 32'h1, 32'h1);
    wr(8'h98, 32'h0);
    rd("R8 zero write keeps status", 8'h98, 32'h1, 32'h1);
    wr(8'hA8, 32'h0);
    rd("R10 source write ignored", 8'hA8, 32'h1, 32'h1);
    pins[64] = 1'b0;
    wait_neg(3);
    pins[64] = 1'b1;
    wait_neg(1);
    wr(8'h98, 32'h1);
    rd("R8 event beats clear same cycle", 8'h98, 32'h1, 32'h1);
    wr(8'h98, 32'h1);
    rd("R8 clear works", 8'h98, 32'h1, 32'h0);
    chk("R9 irq low", {31'd0, irq}, '0);

    // R6 falling and both edges
    wr(8'h58, 32'h0);
    wr(8'h68, 32'h2);
    pins[65] = 1'b1;
    wait_neg(3);
    rd("R6 fall enable ignores rise", 8'h98, 32'h2, 32'h0);
    pins[65] = 1'b0;
    wait_neg(3);
    rd("R6 falling sets status", 8'h98, 32'h2, 32'h2);
    wr(8'h98, 32'hFFFFFFFF);
    wr(8'h58, 32'h4);
    wr(8'h68, 32'h4);
    pins[66] = 1'b1;
    wait_neg(3);
    rd("R6 both: rise", 8'h98, 32'h4, 32'h4);
    wr(8'h98, 32'h4);
    pins[66] = 1'b0;
    wait_neg(3);
    rd("R6 both: fall", 8'h98, 32'h4, 32'h4);
    wr(8'h58, 32'h0);
    wr(8'h68, 32'h0);
    wr(8'h98, 32'hFFFFFFFF);

    // R7 levels, R10 level source
    wr(8'h70, 32'h80);
    pins[7] = 1'b1;
    wait_neg(3);
    rd("R7 high level sets", 8'h90, 32'h80, 32'h80);
    rd("R10 level source is 0", 8'hA0, 32'h80, 32'h0);
    wr(8'h90, 32'h80);
    rd("R7 level re-sets after clear", 8'h90, 32'h80, 32'h80);
    wr(8'h70, 32'h0);
    wr(8'h90, 32'h80);
    rd("R7 clears once disabled", 8'h90, 32'h80, 32'h0);
    pins[7] = 1'b0;
    wr(8'h80, 32'h8);
    wait_neg(2);
    rd("R7 low level sets", 8'h90, 32'h8, 32'h8);

    // R9: several banks feed one line
    wr(8'h88, 32'h20);
    wait_neg(2);
    wr(8'h80, 32'h0);
    wr(8'h90, 32'hFFFFFFFF);
    chk("R9 irq held by bank2", {31'd0, irq}, 32'h1);
    wr(8'h88, 32'h0);
    wr(8'h98, 32'hFFFFFFFF);
    chk("R9 irq drops when all clear", {31'd0, irq}, '0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int op;
      @(negedge clk);
      pins = pins ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                     $urandom & $urandom & $urandom};
      op = $urandom % 3;
      a = {4'($urandom % 12), 2'($urandom % 4), 2'b00};
      if (a[7:4] == 4'd7 || a[7:4] == 4'd8) b_wdata = $urandom & $urandom & $urandom;
      else b_wdata = $urandom;
      b_en = 1'b1; b_we = (op == 0); b_addr = a;
      #1;
      if (!b_we) chk("R1 R6 R8 random read", rdata, exp_read(a));
      chk("R9 random irq", {31'd0, irq}, {31'd0, |m_stat});
      if (i % 50 == 0) begin
        chk("R2 random oe bank0", pin_oe[W-1:0], m_dir[W-1:0]);
        chk("R3 random out bank2", pin_out[3*W-1:2*W], m_dout[3*W-1:2*W]);
      end
    end
    @(negedge clk);
    b_en = 1'b0; b_we = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule